// File: doc/BRIEF.md
# Pipelined Byte-Write Burst SRAM

A synthesizable, reduced-depth model of a synchronous pipelined static RAM. Address, strobes, chip selects, write controls and write data are taken on the rising clock edge. Read data passes through one output register before it reaches the data port. Each word holds four 9-bit lanes: 8 data bits and 1 parity bit per lane. A 2-bit burst sequencer produces up to four addresses from one start address, in linear or interleaved order. Writes can cover any subset of the lanes.

A bus master starts an access with one of two strobes. The processor-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. Later cycles advance the burst, or hold it on the current word to insert wait states. A sleep input gates the block with a two-cycle latency when it is entered and when it is left. An output-enable input gates the data-port drive without using the clock.

Top module: `burst_sram`

## Requirements
- R1: After reset, and until a read has completed, `dout_en` is low.
- R2: A cycle that writes with `gw_n` low stores all four lanes of `din`, whatever `bwe_n` and `lane_we_n` hold.
- R3: With `gw_n` high and `bwe_n` low, only the lanes whose `lane_we_n[i]` bit is low are written. Lane i is `din[9*i+8:9*i]`, where bit 9*i+8 is that lane's parity bit. The other lanes keep their old contents.
- R4: With `gw_n` high and either `bwe_n` high or all `lane_we_n` bits high, the access is a read and no lane changes.
- R5: When `sel_n` is low, a low `proc_strb_n` starts a burst as a read at `addr`, whatever the write controls hold. A write cycle on the next edge, with no strobe and `adv_n` high, writes that same address. When `sel_n` is high, `proc_strb_n` is ignored.
- R6: A burst starts only when `sel_n` is low, `sel2` is high and `sel2_n` is low. A strobe accepted under any other chip-select combination deselects the block and writes nothing.
- R7: While a burst is active and no strobe is accepted, `adv_n` low steps the 2-bit burst count and `adv_n` high holds the current word. The two low address bits are start+count modulo 4 when `interleave` is 0, and start XOR count when `interleave` is 1. The upper address bits are kept from the start address.
- R8: Data read at edge N is driven on `dout` after edge N+1 and stays there until edge N+2, so back-to-back reads stream one word per cycle.
- R9: `oe_n` high forces `dout_en` low at once, without waiting for a clock edge. Lowering `oe_n` again restores the drive of a completed read.
- R10: After a deselect at edge N, `dout_en` is low after edge N+1. Cycles with neither strobe that arrive while no burst is active neither read nor write.
- R11: Sleep raised before edge E0 lets edges E0 and E1 be sampled and ignores every later edge, and `dout_en` is low from E1 on. Sleep lowered before edge F0 makes edges F0 and F1 ignored, and F2 is sampled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr | input | ADDR_W | External word address |
| proc_strb_n | input | 1 | Processor-side start strobe, active low, always starts a read |
| ctl_strb_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Chip select, active low; also masks `proc_strb_n` |
| sel2 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| lane_we_n | input | LANES | Per-lane write selects, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | High when `dout` is being driven |

## Verification
The sharpest collision comes when a read is registered on one edge and the next edge both loads the output register from that address and writes that same address. The processor-strobe read followed by its write cycle creates exactly this case. The bench expects the old contents on the port and the new contents on a later read. The bench also lets sleep entry overlap a read already in the pipeline, and expects the data to stay undriven even though the read completed. An exhaustive sweep of the 64 combinations of `gw_n`, `bwe_n` and `lane_we_n` is compared, lane by lane, against a masked shadow array.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_START = 2'd1,
    ACT_CONT  = 2'd2,
    ACT_DESEL = 2'd3
  } bact_e;

  // Low address bits for a given burst count.
  function automatic logic [BURST_W-1:0] burst_offset(
    input logic               il,
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] cnt
  );
    return il ? (start ^ cnt) : (start + cnt);
  endfunction

endpackage

// File: rtl/bsram_cmd_dec.sv
module bsram_cmd_dec
  import bsram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             awake,
  input  logic             burst_act,
  input  logic             sel_n,
  input  logic             sel2,
  input  logic             sel2_n,
  input  logic             proc_strb_n,
  input  logic             ctl_strb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  output bact_e            act,
  output logic             step,
  output logic             acc,
  output logic [LANES-1:0] wmask
);

  logic             sel_all;
  logic [LANES-1:0] wr_sel;

  always_comb begin
    sel_all = ~sel_n & sel2 & ~sel2_n;
    if (!gw_n)       wr_sel = '1;
    else if (!bwe_n) wr_sel = ~lane_we_n;
    else             wr_sel = '0;

    act   = ACT_NONE;
    step  = 1'b0;
    acc   = 1'b0;
    wmask = '0;
    if (awake) begin
      if (!proc_strb_n && !sel_n) begin
        // processor strobe: start always reads
        if (sel_all) begin
          act = ACT_START;
          acc = 1'b1;
        end else begin
          act = ACT_DESEL;
        end
      end else if (!ctl_strb_n) begin
        if (sel_all) begin
          act   = ACT_START;
          acc   = 1'b1;
          wmask = wr_sel;
        end else begin
          act = ACT_DESEL;
        end
      end else if (burst_act) begin
        act   = ACT_CONT;
        acc   = 1'b1;
        step  = ~adv_n;
        wmask = wr_sel;
      end
    end
  end

endmodule

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              interleave,
  input  bact_e             act,
  input  logic              step,
  input  logic              flush,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic              burst_act,
  output logic [ADDR_W-1:0] acc_addr
);

  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  base_q, base_d;
  logic [BURST_W-1:0] cnt_q, cnt_d;
  logic               act_q, act_d;
  logic               load_en;

  always_comb begin
    base_d  = base_q;
    cnt_d   = cnt_q;
    act_d   = act_q;
    load_en = (act == ACT_START);
    if (flush) begin
      act_d = 1'b0;
    end else begin
      case (act)
        ACT_START: begin
          base_d = ext_addr;
          cnt_d  = '0;
          act_d  = 1'b1;
        end
        ACT_DESEL: act_d = 1'b0;
        ACT_CONT:  if (step) cnt_d = cnt_q + 1'b1;
        default: ;
      endcase
    end
    if (load_en)
      acc_addr = ext_addr;
    else
      acc_addr = {base_q[ADDR_W-1 -: HI_W],
                  burst_offset(interleave, base_q[BURST_W-1:0], cnt_d)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      act_q  <= 1'b0;
    end else begin
      if (load_en) base_q <= base_d;
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign burst_act = act_q;

  // R7: an advancing continuation steps the count by one, modulo 4
  a_r7_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CONT && step && !flush) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R7: a suspended continuation keeps the count
  a_r7_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_CONT && !step && !flush) |=> $stable(cnt_q));

  // R6: a start loads the external address and clears the count
  a_r6_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_START && !flush) |=> (base_q == $past(ext_addr) && cnt_q == '0 && act_q));

endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES-1:0]        we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];

    // R3: an enabled lane holds its write data after the edge
    a_r3_lane_write: assert property (@(posedge clk) disable iff (!rst_n)
      we[g] |=> (mem[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W])));
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    interleave,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    proc_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    adv_n,
  input  logic                    sel_n,
  input  logic                    sel2,
  input  logic                    sel2_n,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        lane_we_n,
  input  logic                    oe_n,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  // reset: asynchronous assert, synchronous release
  logic rst_q1, rst_q2, rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1 <= 1'b0;
      rst_q2 <= 1'b0;
    end else begin
      rst_q1 <= 1'b1;
      rst_q2 <= rst_q1;
    end
  end
  assign rst_ni = rst_q2;

  // sleep synchroniser: two edges of latency on entry and on exit
  logic zz_q1, zz_q2, asleep, awake;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      zz_q1 <= 1'b0;
      zz_q2 <= 1'b0;
    end else begin
      zz_q1 <= sleep;
      zz_q2 <= zz_q1;
    end
  end
  assign asleep = zz_q2;
  assign awake  = ~zz_q2;

  // command decode
  bact_e             dec_act;
  logic              dec_step, dec_acc, burst_act;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] acc_addr;

  bsram_cmd_dec #(.LANES(LANES)) u_dec (
    .awake      (awake),
    .burst_act  (burst_act),
    .sel_n      (sel_n),
    .sel2       (sel2),
    .sel2_n     (sel2_n),
    .proc_strb_n(proc_strb_n),
    .ctl_strb_n (ctl_strb_n),
    .adv_n      (adv_n),
    .gw_n       (gw_n),
    .bwe_n      (bwe_n),
    .lane_we_n  (lane_we_n),
    .act        (dec_act),
    .step       (dec_step),
    .acc        (dec_acc),
    .wmask      (lane_we)
  );

  bsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ni),
    .interleave(interleave),
    .act       (dec_act),
    .step      (dec_step),
    .flush     (asleep),
    .ext_addr  (addr),
    .burst_act (burst_act),
    .acc_addr  (acc_addr)
  );

  // read pipeline: address register, then output register
  logic              rd_req;
  logic              rd_pend_q, rd_pend_d;
  logic              out_vld_q, out_vld_d;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] mem_rdata, dout_q;

  bsram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk  (clk),
    .rst_n(rst_ni),
    .we   (lane_we),
    .waddr(acc_addr),
    .wdata(din),
    .raddr(rd_addr_q),
    .rdata(mem_rdata)
  );

  always_comb begin
    rd_req    = dec_acc & ~(|lane_we);
    rd_pend_d = rd_req;
    out_vld_d = rd_pend_q & awake;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      out_vld_q <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      out_vld_q <= out_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req)    rd_addr_q <= acc_addr;
    if (rd_pend_q) dout_q    <= mem_rdata;
  end

  assign dout    = dout_q;
  assign dout_en = out_vld_q & ~oe_n & ~asleep;

  // R8: data on the port comes from a read requested two edges earlier
  a_r8_pipe: assert property (@(posedge clk) disable iff (!rst_ni)
    out_vld_q |-> $past(rd_req, 2));

  // R10: deselect leaves the port undriven one cycle later
  a_r10_desel_z: assert property (@(posedge clk) disable iff (!rst_ni)
    (dec_act == ACT_DESEL) |-> ##2 !dout_en);

  // R5: a processor strobe that passes the select mask never writes
  a_r5_proc_no_write: assert property (@(posedge clk) disable iff (!rst_ni)
    (!proc_strb_n && !sel_n) |-> (lane_we == '0));

  // R11: sleep takes effect two edges after the request
  a_r11_sleep_enter: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(asleep) |-> $past(sleep, 2));

  // R11: wake takes effect two edges after release
  a_r11_sleep_exit: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(asleep) |-> !$past(sleep, 2));

endmodule

// File: tb/tb_burst_sram.sv
`timescale 1ns/1ps
module tb_burst_sram;

  localparam int AW = 6;
  localparam int DW = 36;

  logic          clk;
  logic          rst_n;
  logic          interleave;
  logic [AW-1:0] addr;
  logic          proc_strb_n, ctl_strb_n, adv_n;
  logic          sel_n, sel2, sel2_n;
  logic          gw_n, bwe_n;
  logic [3:0]    lane_we_n;
  logic          oe_n, sleep;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [DW-1:0] shadow [64];

  burst_sram dut (
    .clk(clk), .rst_n(rst_n), .interleave(interleave), .addr(addr),
    .proc_strb_n(proc_strb_n), .ctl_strb_n(ctl_strb_n), .adv_n(adv_n),
    .sel_n(sel_n), .sel2(sel2), .sel2_n(sel2_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_we_n(lane_we_n), .oe_n(oe_n), .sleep(sleep), .din(din),
    .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return (36'(a) * 36'd2654435761) ^ (36'(salt) << 11) ^ 36'hA5C31F0E7;
  endfunction

  function automatic logic [3:0] emask(input logic g, input logic b, input logic [3:0] ln);
    if (!g) return 4'hF;
    if (!b) return ~ln;
    return 4'h0;
  endfunction

  function automatic logic [AW-1:0] bexp(input logic [AW-1:0] base, input int cnt, input logic il);
    logic [1:0] lo;
    lo = il ? (base[1:0] ^ 2'(cnt)) : (base[1:0] + 2'(cnt));
    return {base[AW-1:2], lo};
  endfunction

  task automatic apply(input logic [AW-1:0] a, input logic [3:0] m, input logic [DW-1:0] d);
    for (int i = 0; i < 4; i++)
      if (m[i]) shadow[a][9*i +: 9] = d[9*i +: 9];
  endtask

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic p, input logic c, input logic s, input logic s2,
                     input logic s2n, input logic a, input logic g, input logic b,
                     input logic [3:0] ln, input logic [AW-1:0] ad, input logic [DW-1:0] d);
    proc_strb_n = p; ctl_strb_n = c; sel_n = s; sel2 = s2; sel2_n = s2n;
    adv_n = a; gw_n = g; bwe_n = b; lane_we_n = ln; addr = ad; din = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_wr(input logic [AW-1:0] a, input logic g, input logic b,
                        input logic [3:0] ln, input logic [DW-1:0] d);
    cyc(1, 0, 0, 1, 0, 1, g, b, ln, a, d);
  endtask

  task automatic ctl_rd(input logic [AW-1:0] a);
    cyc(1, 0, 0, 1, 0, 1, 1, 1, 4'hF, a, '0);
  endtask

  task automatic cont(input logic a, input logic g, input logic b,
                      input logic [3:0] ln, input logic [DW-1:0] d);
    cyc(1, 1, 0, 1, 0, a, g, b, ln, '0, d);
  endtask

  task automatic desel();
    cyc(1, 0, 0, 0, 0, 1, 1, 1, 4'hF, '0, '0);
  endtask

  task automatic rdchk(input logic [AW-1:0] a, input string req);
    ctl_rd(a);
    desel();
    chk(req, dout, shadow[a]);
    chk(req, {35'd0, dout_en}, 36'd1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    logic [AW-1:0] old_a;
    int cnt_tab [6];
    logic adv_tab [6];

    rst_n = 0; interleave = 0; oe_n = 0; sleep = 0;
    proc_strb_n = 1; ctl_strb_n = 1; adv_n = 1; sel_n = 0; sel2 = 0; sel2_n = 0;
    gw_n = 1; bwe_n = 1; lane_we_n = 4'hF; addr = '0; din = '0;
    repeat (3) @(negedge clk);
    chk("R1 port idle in reset", {35'd0, dout_en}, 36'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    desel();
    chk("R1 port idle after reset", {35'd0, dout_en}, 36'd0);

    // fill with global write, ignoring lane bits (R2)
    for (int a = 0; a < 64; a++) begin
      ctl_wr(6'(a), 0, 0, 4'(a), pat(a, 0));
      shadow[a] = pat(a, 0);
    end
    // streaming readback: one word per cycle (R8, R2)
    for (int a = 0; a <= 64; a++) begin
      if (a < 64) ctl_rd(6'(a));
      else        desel();
      if (a > 0) begin
        chk("R8 R2 streamed read data", dout, shadow[a-1]);
        chk("R8 streamed read drive", {35'd0, dout_en}, 36'd1);
      end
    end
    desel();
    chk("R10 idle after deselect", {35'd0, dout_en}, 36'd0);

    // exhaustive write-control sweep (R2 R3 R4)
    for (int c = 0; c < 64; c++) begin
      logic g, b;
      logic [3:0] ln;
      g = c[5]; b = c[4]; ln = c[3:0];
      ctl_wr(6'd9, g, b, ln, pat(c, 5));
      apply(6'd9, emask(g, b, ln), pat(c, 5));
      rdchk(6'd9, "R3 R4 R2 lane mask sweep");
    end

    // burst orders with a suspend in the middle (R7)
    cnt_tab = '{0, 1, 1, 2, 3, 0};
    adv_tab = '{1, 0, 1, 0, 0, 0};
    for (int il = 0; il < 2; il++) begin
      interleave = il[0];
      for (int s = 0; s < 4; s++) begin
        base = 6'h2C | 6'(s);
        for (int j = 0; j < 6; j++) begin
          if (j == 0) ctl_rd(base);
          else        cont(adv_tab[j], 1, 1, 4'hF, '0);
          if (j > 0)
            chk("R7 burst read order", dout, shadow[bexp(base, cnt_tab[j-1], il[0])]);
        end
        desel();
        chk("R7 burst read last", dout, shadow[bexp(base, cnt_tab[5], il[0])]);
        desel();
        chk("R10 undriven after deselect", {35'd0, dout_en}, 36'd0);
      end
    end

    // burst writes in both orders (R7)
    for (int il = 0; il < 2; il++) begin
      interleave = il[0];
      base = il ? 6'h36 : 6'h31;
      for (int j = 0; j < 4; j++) begin
        if (j == 0) ctl_wr(base, 0, 1, 4'hF, pat(j, 40 + il));
        else        cont(0, 0, 1, 4'hF, pat(j, 40 + il));
        apply(bexp(base, j, il[0]), 4'hF, pat(j, 40 + il));
      end
      desel();
    end
    interleave = 0;
    for (int a = 6'h30; a < 6'h38; a++) rdchk(6'(a), "R7 burst write placement");

    // processor strobe: read first, then write on the next edge (R5)
    old_a = 6'h07;
    cyc(0, 1, 0, 1, 0, 1, 0, 0, 4'h0, old_a, pat(7, 60));
    cont(1, 0, 1, 4'hF, pat(7, 61));
    chk("R5 strobe reads old word", dout, shadow[old_a]);
    apply(old_a, 4'hF, pat(7, 61));
    desel();
    rdchk(old_a, "R5 following-edge write");

    // processor strobe masked by sel_n acts as a continuation (R5)
    ctl_rd(6'h10);
    cyc(0, 1, 1, 1, 0, 0, 1, 1, 4'hF, 6'h3F, '0);
    chk("R5 first burst word", dout, shadow[6'h10]);
    desel();
    chk("R5 masked strobe continues burst", dout, shadow[6'h11]);

    // chip-select combinations that must not start (R6)
    desel();
    cyc(1, 0, 0, 0, 0, 1, 0, 1, 4'hF, 6'h03, pat(3, 70));
    cyc(1, 0, 0, 1, 1, 1, 0, 1, 4'hF, 6'h04, pat(4, 70));
    cyc(1, 0, 1, 1, 0, 1, 0, 1, 4'hF, 6'h05, pat(5, 70));
    chk("R6 no drive on bad select", {35'd0, dout_en}, 36'd0);
    cyc(0, 1, 0, 0, 0, 1, 1, 1, 4'hF, 6'h06, '0);
    desel();
    chk("R6 proc strobe with sel2 low", {35'd0, dout_en}, 36'd0);
    rdchk(6'h03, "R6 no write sel2 low");
    rdchk(6'h04, "R6 no write sel2_n high");
    rdchk(6'h05, "R6 no write sel_n high");

    // no burst active: continuation does nothing (R10)
    desel();
    cont(0, 0, 1, 4'hF, pat(1, 80));
    cont(1, 1, 1, 4'hF, '0);
    desel();
    chk("R10 continuation without burst", {35'd0, dout_en}, 36'd0);
    rdchk(6'h00, "R10 no stray write");

    // asynchronous output enable (R9)
    ctl_rd(6'h02);
    desel();
    oe_n = 1; #2;
    chk("R9 oe high releases port", {35'd0, dout_en}, 36'd0);
    oe_n = 0; #2;
    chk("R9 oe low restores drive", {35'd0, dout_en}, 36'd1);
    oe_n = 1;
    ctl_rd(6'h02);
    desel();
    chk("R9 read with oe high", {35'd0, dout_en}, 36'd0);
    oe_n = 0; #2;
    chk("R9 late enable drives data", dout, shadow[6'h02]);
    desel();

    // sleep entry and exit latency (R11)
    sleep = 1;
    ctl_rd(6'h20);
    ctl_wr(6'h38, 0, 1, 4'hF, pat(0, 90));
    chk("R11 port undriven in sleep", {35'd0, dout_en}, 36'd0);
    apply(6'h38, 4'hF, pat(0, 90));
    ctl_wr(6'h39, 0, 1, 4'hF, pat(1, 90));
    sleep = 0;
    ctl_wr(6'h3A, 0, 1, 4'hF, pat(2, 90));
    ctl_wr(6'h3B, 0, 1, 4'hF, pat(3, 90));
    ctl_wr(6'h3C, 0, 1, 4'hF, pat(4, 90));
    apply(6'h3C, 4'hF, pat(4, 90));
    desel();
    for (int a = 6'h38; a <= 6'h3C; a++) rdchk(6'(a), "R11 sampling window");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule